// File: doc/BRIEF.md
# Serializer Round-Robin Data Port

This block puts one host data address in front of a bank of up to sixteen serializer lanes. Each lane is switched on by an activity mask and set by a direction mask to either transmit or receive. A host writes 32-bit words to the single address. The block steers each word to the pending transmit lane with the lowest index. Lanes that are inactive or that receive are skipped. A read from the same address returns the receive words that were captured for the current frame, also in ascending lane order.

A single-cycle frame tick stands in for the serial timing. On each tick the block does four things. It re-arms the full set of transmit lanes. It captures one word from every receive lane. It raises one transmit event and one receive event for the whole frame. It checks whether the last frame was fully served. If a lane was not written before the tick, that lane is loaded with zero and an underrun pulse is raised. A write that arrives when no lane is pending is dropped and an overrun pulse is raised. The masks are sampled only while the block is disabled.

Top module: `srr_data_port`

## Requirements
- R1: `cfg_active` and `cfg_xmit` are sampled only while `enable` is low. Changes to them while `enable` is high have no effect on steering until the block is disabled again.
- R2: An accepted write is delivered to the pending transmit lane with the lowest index, that is, a lane whose `cfg_active` and `cfg_xmit` bits are both 1. In the cycle after the write, that lane's `tx_load` bit is 1 and its slice `tx_words[i*32 +: 32]` holds the word. Lanes are served in strictly ascending order within a frame.
- R3: A frame tick while enabled makes every transmit lane pending again. `xmit_evt` pulses for one cycle in the cycle after the tick, if at least one transmit lane exists.
- R4: A write while enabled with no lane pending pulses `err_overrun` in the next cycle. This includes every write before the first tick. The word is dropped and no `tx_load` bit rises for it.
- R5: At a tick, every lane still pending from the previous frame is loaded with zero, with its `tx_load` bit set in the next cycle, and `err_underrun` pulses in that same cycle.
- R6: A read while enabled returns, in `host_rdata` in the next cycle, the captured word of the pending receive lane with the lowest index, and that lane is then no longer pending. A read with no lane pending returns zero.
- R7: A tick while enabled captures `rx_words` for every receive lane (`cfg_active` 1, `cfg_xmit` 0) and makes all of them pending. `rcv_evt` pulses in the next cycle if at least one receive lane exists.
- R8: While `enable` is low, writes, reads and ticks are ignored. No load, error or event is produced, and all pending state is cleared.
- R9: A write in the same cycle as a tick belongs to the new frame. It goes to the lowest transmit lane after any zero fill from R5, and its data takes the place of that lane's zero fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; masks are sampled while low |
| cfg_active | input | NUM_SER | Lane activity mask |
| cfg_xmit | input | NUM_SER | Lane direction, 1 = transmit, 0 = receive |
| frame_tick | input | 1 | One-cycle frame boundary |
| host_wr | input | 1 | Host write strobe to the shared address |
| host_wdata | input | DATA_W | Host write word |
| host_rd | input | 1 | Host read strobe from the shared address |
| host_rdata | output | DATA_W | Read word, valid the cycle after `host_rd` |
| rx_words | input | NUM_SER*DATA_W | Received word of each lane, lane i at bits i*DATA_W |
| tx_load | output | NUM_SER | Per-lane load strobe |
| tx_words | output | NUM_SER*DATA_W | Per-lane transmit word, lane i at bits i*DATA_W |
| xmit_evt | output | 1 | One pulse per frame requesting transmit words |
| rcv_evt | output | 1 | One pulse per frame announcing receive words |
| err_overrun | output | 1 | Write dropped, no lane pending |
| err_underrun | output | 1 | Frame ended with unserved transmit lanes |

## Verification
The bench uses a sparse lane set with gaps and checks that words skip the inactive lanes and the receive lanes. A design that walked the lanes contiguously or wrapped its pointer would put data on the wrong lane. It then writes one word too many and one word too few per frame, and checks that the extra word is dropped with an overrun and that the missing lanes go out as zero with an underrun. A design that reused stale data, or that wrapped around and overwrote lane 0, would be caught here. It also changes the masks while enabled, writes while disabled, and writes in the same cycle as a tick. A design that took the masks live, acted while off, or applied the tick-cycle write to the old frame would show wrong loads.

// File: rtl/srr_pkg.sv
package srr_pkg;

    localparam int SRR_MAX_LANES = 16;
    localparam int SRR_IDX_W     = $clog2(SRR_MAX_LANES);

    typedef logic [SRR_MAX_LANES-1:0] srr_mask_t;

    typedef struct packed {
        logic                 hit;
        logic [SRR_IDX_W-1:0] idx;
    } srr_pick_t;

    typedef struct packed {
        logic overrun;
        logic underrun;
        logic evt;
    } srr_tx_flags_t;

    // lowest set bit of a lane mask
    function automatic srr_pick_t srr_lowest(srr_mask_t m);
        srr_pick_t p;
        p = '0;
        for (int i = SRR_MAX_LANES - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.hit = 1'b1;
                p.idx = SRR_IDX_W'(i);
            end
        end
        return p;
    endfunction

    function automatic srr_mask_t srr_onehot(srr_pick_t p);
        srr_mask_t m;
        m = '0;
        if (p.hit) m[p.idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/srr_cfg_shadow.sv
module srr_cfg_shadow
    import srr_pkg::*;
#(
    parameter int NUM_SER = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic [NUM_SER-1:0] cfg_active,
    input  logic [NUM_SER-1:0] cfg_xmit,
    output srr_mask_t          tx_set,
    output srr_mask_t          rx_set
);

    srr_mask_t act_pad, dir_pad;

    always_comb begin
        act_pad = '0;
        dir_pad = '0;
        act_pad[NUM_SER-1:0] = cfg_active;
        dir_pad[NUM_SER-1:0] = cfg_xmit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_set <= '0;
            rx_set <= '0;
        end else if (!enable) begin
            tx_set <= act_pad & dir_pad;
            rx_set <= act_pad & ~dir_pad;
        end
    end

endmodule

// File: rtl/srr_tx_steer.sv
module srr_tx_steer
    import srr_pkg::*;
#(
    parameter int NUM_SER = 16,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic                      frame_tick,
    input  logic                      host_wr,
    input  logic [DATA_W-1:0]         host_wdata,
    input  srr_mask_t                 tx_set,
    output logic [NUM_SER-1:0]        tx_load,
    output logic [NUM_SER*DATA_W-1:0] tx_words,
    output srr_tx_flags_t             flags
);

    srr_mask_t pend_q, base, after, fill, hit_mask, load_d, load_q;
    srr_pick_t pick;
    logic      wr_take;

    always_comb begin
        base     = frame_tick ? tx_set : pend_q;
        pick     = srr_lowest(base);
        wr_take  = host_wr && pick.hit;
        hit_mask = wr_take ? srr_onehot(pick) : '0;
        after    = base & ~hit_mask;
        fill     = frame_tick ? pend_q : '0;
        load_d   = fill | hit_mask;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            pend_q <= '0;
            load_q <= '0;
            flags  <= '0;
        end else begin
            pend_q         <= after;
            load_q         <= load_d;
            flags.overrun  <= host_wr && !pick.hit;
            flags.underrun <= frame_tick && (pend_q != '0);
            flags.evt      <= frame_tick && (tx_set != '0);
        end
    end

    assign tx_load = load_q[NUM_SER-1:0];

    for (genvar i = 0; i < NUM_SER; i++) begin : g_lane
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (enable) begin
                if (hit_mask[i])  word_q <= host_wdata;
                else if (fill[i]) word_q <= '0;
            end
        end
        assign tx_words[i*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/srr_rx_gather.sv
module srr_rx_gather
    import srr_pkg::*;
#(
    parameter int NUM_SER = 16,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic                      frame_tick,
    input  logic                      host_rd,
    input  srr_mask_t                 rx_set,
    input  logic [NUM_SER*DATA_W-1:0] rx_words,
    output logic [DATA_W-1:0]         host_rdata,
    output logic                      rcv_evt
);

    logic [DATA_W-1:0] cap_q  [SRR_MAX_LANES];
    logic [DATA_W-1:0] live_w [SRR_MAX_LANES];
    srr_mask_t         pend_q, base, taken;
    srr_pick_t         pick;
    logic [DATA_W-1:0] src;

    for (genvar i = 0; i < SRR_MAX_LANES; i++) begin : g_pad
        if (i < NUM_SER) begin : g_real
            assign live_w[i] = rx_words[i*DATA_W +: DATA_W];
        end else begin : g_none
            assign live_w[i] = '0;
        end
        always_ff @(posedge clk) begin
            if (rst)                      cap_q[i] <= '0;
            else if (enable && frame_tick) cap_q[i] <= live_w[i];
        end
    end

    always_comb begin
        base  = frame_tick ? rx_set : pend_q;
        pick  = srr_lowest(base);
        taken = (host_rd && pick.hit) ? srr_onehot(pick) : '0;
        src   = frame_tick ? live_w[pick.idx] : cap_q[pick.idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= '0;
            rcv_evt    <= 1'b0;
            host_rdata <= '0;
        end else if (!enable) begin
            pend_q  <= '0;
            rcv_evt <= 1'b0;
        end else begin
            pend_q  <= base & ~taken;
            rcv_evt <= frame_tick && (rx_set != '0);
            if (host_rd) host_rdata <= pick.hit ? src : '0;
        end
    end

endmodule

// File: rtl/srr_data_port.sv
module srr_data_port
    import srr_pkg::*;
#(
    parameter int NUM_SER = 16,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic [NUM_SER-1:0]        cfg_active,
    input  logic [NUM_SER-1:0]        cfg_xmit,
    input  logic                      frame_tick,
    input  logic                      host_wr,
    input  logic [DATA_W-1:0]         host_wdata,
    input  logic                      host_rd,
    output logic [DATA_W-1:0]         host_rdata,
    input  logic [NUM_SER*DATA_W-1:0] rx_words,
    output logic [NUM_SER-1:0]        tx_load,
    output logic [NUM_SER*DATA_W-1:0] tx_words,
    output logic                      xmit_evt,
    output logic                      rcv_evt,
    output logic                      err_overrun,
    output logic                      err_underrun
);

    srr_mask_t     tx_set, rx_set;
    srr_tx_flags_t tx_flags;

    srr_cfg_shadow #(.NUM_SER(NUM_SER)) u_shadow (
        .clk(clk), .rst(rst), .enable(enable),
        .cfg_active(cfg_active), .cfg_xmit(cfg_xmit),
        .tx_set(tx_set), .rx_set(rx_set)
    );

    srr_tx_steer #(.NUM_SER(NUM_SER), .DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst(rst), .enable(enable), .frame_tick(frame_tick),
        .host_wr(host_wr), .host_wdata(host_wdata), .tx_set(tx_set),
        .tx_load(tx_load), .tx_words(tx_words), .flags(tx_flags)
    );

    srr_rx_gather #(.NUM_SER(NUM_SER), .DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst(rst), .enable(enable), .frame_tick(frame_tick),
        .host_rd(host_rd), .rx_set(rx_set), .rx_words(rx_words),
        .host_rdata(host_rdata), .rcv_evt(rcv_evt)
    );

    assign xmit_evt     = tx_flags.evt;
    assign err_overrun  = tx_flags.overrun;
    assign err_underrun = tx_flags.underrun;

endmodule

// File: rtl/srr_data_port_chk.sv
module srr_data_port_chk
    import srr_pkg::*;
#(
    parameter int NUM_SER = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               enable,
    input logic               frame_tick,
    input logic [NUM_SER-1:0] tx_load,
    input logic               xmit_evt,
    input logic               rcv_evt,
    input logic               err_overrun,
    input logic               err_underrun,
    input srr_mask_t          tx_set,
    input srr_mask_t          rx_set
);

    p_masks_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable)) |-> ($stable(tx_set) && $stable(rx_set)));

    p_single_lane_r2: assert property (@(posedge clk) disable iff (rst)
        !err_underrun |-> $onehot0(tx_load));

    p_evt_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        xmit_evt |-> ($past(frame_tick) && $past(enable)));

    p_overrun_drops_r4: assert property (@(posedge clk) disable iff (rst)
        (err_overrun && !err_underrun) |-> (tx_load == '0));

    p_underrun_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        err_underrun |-> $past(frame_tick));

    p_rx_evt_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
        rcv_evt |-> ($past(frame_tick) && $past(enable)));

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> (tx_load == '0 && !xmit_evt && !rcv_evt
                            && !err_overrun && !err_underrun));

endmodule

bind srr_data_port srr_data_port_chk #(.NUM_SER(NUM_SER)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .frame_tick(frame_tick),
    .tx_load(tx_load), .xmit_evt(xmit_evt), .rcv_evt(rcv_evt),
    .err_overrun(err_overrun), .err_underrun(err_underrun),
    .tx_set(tx_set), .rx_set(rx_set)
);

// File: tb/srr_data_port_bench.sv
`timescale 1ns/1ps
module srr_data_port_bench;

    localparam int NS = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [NS-1:0] act = '0, xm = '0;
    logic          tick = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [DW-1:0] wd = '0;
    logic [NS*DW-1:0] rxw = '0;
    logic [DW-1:0] rdata;
    logic [NS-1:0] tx_load;
    logic [NS*DW-1:0] tx_words;
    logic          xevt, revt, ovr, und;

    int tests = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    srr_data_port #(.NUM_SER(NS), .DATA_W(DW)) u_srr_data_port (
        .clk(clk), .rst(rst), .enable(en), .cfg_active(act), .cfg_xmit(xm),
        .frame_tick(tick), .host_wr(wr), .host_wdata(wd), .host_rd(rd),
        .host_rdata(rdata), .rx_words(rxw), .tx_load(tx_load),
        .tx_words(tx_words), .xmit_evt(xevt), .rcv_evt(revt),
        .err_overrun(ovr), .err_underrun(und)
    );

    // behavioural reference
    logic [NS-1:0] sh_act = '0, sh_xm = '0, m_load = '0;
    logic [DW-1:0] m_data [NS];
    logic [DW-1:0] m_rdata = '0;
    logic m_xevt = 0, m_revt = 0, m_ovr = 0, m_und = 0, m_rdv = 0;
    int            txq[$];
    logic [DW-1:0] rxq[$];

    initial for (int i = 0; i < NS; i++) m_data[i] = '0;

    always @(posedge clk) begin
        m_load = '0; m_xevt = 0; m_revt = 0; m_ovr = 0; m_und = 0; m_rdv = 0;
        if (rst) begin
            sh_act = '0; sh_xm = '0; txq.delete(); rxq.delete(); m_rdata = '0;
            for (int i = 0; i < NS; i++) m_data[i] = '0;
        end else if (!en) begin
            sh_act = act; sh_xm = xm; txq.delete(); rxq.delete();
        end else begin
            if (tick) begin
                m_und = (txq.size() > 0);
                foreach (txq[k]) begin m_load[txq[k]] = 1'b1; m_data[txq[k]] = '0; end
                txq.delete(); rxq.delete();
                for (int i = 0; i < NS; i++) begin
                    if (sh_act[i] && sh_xm[i]) txq.push_back(i);
                    if (sh_act[i] && !sh_xm[i]) rxq.push_back(rxw[i*DW +: DW]);
                end
                m_xevt = (txq.size() > 0);
                m_revt = (rxq.size() > 0);
            end
            if (wr) begin
                if (txq.size() > 0) begin
                    int l;
                    l = txq.pop_front();
                    m_load[l] = 1'b1; m_data[l] = wd;
                end else m_ovr = 1;
            end
            if (rd) begin
                m_rdv = 1;
                m_rdata = (rxq.size() > 0) ? rxq.pop_front() : '0;
            end
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] a, input logic [DW-1:0] e);
        tests++;
        if (a !== e) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            int bad;
            check("R2 tx_load", DW'(tx_load), DW'(m_load));
            bad = 0;
            for (int i = 0; i < NS; i++)
                if (tx_words[i*DW +: DW] !== m_data[i]) bad = i + 1;
            if (bad != 0) check("R2 tx_words lane", tx_words[(bad-1)*DW +: DW], m_data[bad-1]);
            else tests++;
            check("R3 xmit_evt", DW'(xevt), DW'(m_xevt));
            check("R7 rcv_evt", DW'(revt), DW'(m_revt));
            check("R4 err_overrun", DW'(ovr), DW'(m_ovr));
            check("R5 err_underrun", DW'(und), DW'(m_und));
            if (m_rdv) check("R6 host_rdata", rdata, m_rdata);
        end
    end

    // stimulus helpers: drive at negedge, release at next negedge
    int frame_no = 0;
    task automatic do_tick();
        frame_no++;
        for (int i = 0; i < NS; i++) rxw[i*DW +: DW] = {16'(frame_no), 16'(i)};
        tick = 1; @(negedge clk); tick = 0;
    endtask
    task automatic do_wr(input logic [DW-1:0] d);
        wr = 1; wd = d; @(negedge clk); wr = 0;
    endtask
    task automatic do_rd();
        rd = 1; @(negedge clk); rd = 0;
    endtask
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1; tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        @(negedge clk);
        check("R2 reset tx_load", DW'(tx_load), '0);
        check("R6 reset host_rdata", rdata, '0);
        // tx lanes {0,4,5,7}, rx lanes {1,9}
        act = 16'h02B3; xm = 16'h00B1;
        idle(2);
        en = 1;
        idle(1);
        do_wr(32'hDEAD0001);                   // R4: before first tick
        check("R4 early write dropped", DW'(ovr), 1);
        do_tick();
        do_wr(32'hA0); do_wr(32'hA4); do_wr(32'hA5);
        check("R2 third word lane5", tx_words[5*DW +: DW], 32'hA5);
        do_wr(32'hA7);
        do_wr(32'hBAD0);                       // R4: overrun
        do_rd(); do_rd(); do_rd();             // R6: third read empty
        check("R6 empty read zero", rdata, '0);
        // underrun: two of four then tick
        do_tick();
        do_wr(32'hB0); do_wr(32'hB4);
        do_tick();
        check("R5 lane7 zero fill", tx_words[7*DW +: DW], '0);
        idle(1);
        // R1: mask changes while enabled ignored
        act = 16'h0004; xm = 16'h0004;
        do_wr(32'hC0);
        check("R1 old mask steers lane0", tx_words[0], 32'hC0 & 1);
        check("R1 lane0 word", tx_words[0 +: DW], 32'hC0);
        do_wr(32'hC4); do_wr(32'hC5); do_wr(32'hC7);
        do_rd(); do_rd();
        // R9: write in tick cycle
        tick = 1; wr = 1; wd = 32'hE0; frame_no++;
        @(negedge clk); tick = 0; wr = 0;
        check("R9 tick write to lane0", DW'(tx_load), 32'h1);
        check("R9 tick write data", tx_words[0 +: DW], 32'hE0);
        // R8: disable, writes and ticks ignored
        en = 0;
        idle(1);
        do_wr(32'hF1); do_tick();
        check("R8 no load when off", DW'(tx_load), '0);
        check("R8 no overrun when off", DW'(ovr), '0);
        // new set tx {3,15}, rx {0}
        act = 16'h8009; xm = 16'h8008;
        idle(1);
        en = 1;
        do_tick();
        do_rd(); do_wr(32'h33); do_wr(32'hFF);
        check("R2 high lane", tx_words[15*DW +: DW], 32'hFF);
        do_wr(32'h99);
        // tick + read same cycle
        for (int i = 0; i < NS; i++) rxw[i*DW +: DW] = 32'h7000 + i;
        tick = 1; rd = 1; @(negedge clk); tick = 0; rd = 0;
        check("R7 tick read live word", rdata, 32'h7000);
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule